// File: doc/BRIEF.md
# Angle Movement Threshold Alert

This block watches a stream of 16-bit angle samples and flags when the angle has travelled further than a programmed distance from a stored reference angle. The full angle range is one turn: the top bit stands for 180°, so one count is roughly 0.0055°. Movement is measured as the shortest signed distance around the circle. A step across the 0/360° seam therefore counts as a small move, and movement in either direction counts.

Each instance holds its own threshold input, so neighbouring channels can alert at different distances. A threshold of zero turns the alert off, and zero is the state after reset. Whenever the alert fires, the current sample becomes the new reference, and a sticky status flag is set. An interrupt line reports the status flag while interrupts are enabled. Software clears the flag with a one-cycle clear pulse.

Top module: `angle_delta_alert`

## Requirements
- R1: After reset, alert_o and irq_o are 0 and no reference angle is held.
- R2: While thresh_i is 0 the block is off: no sample sets alert_o, and the stored reference is discarded.
- R3: While the block is on and holds no reference, the next sample with angle_vld_i = 1 becomes the reference and never sets alert_o.
- R4: Movement is (angle_i − reference) taken modulo 2^16 and read as a signed 16-bit value; its magnitude (0 to 32768) is used, so moves in both directions and across the 0/65535 seam are measured the short way round.
- R5: With a reference held, a valid sample whose movement magnitude is strictly greater than the effective threshold sets alert_o at the next clock edge. A magnitude equal to the threshold does not set it.
- R6: A nonzero thresh_i below 9 acts as an effective threshold of 9.
- R7: A thresh_i above 32749 acts as an effective threshold of 32749, so a move of exactly half a turn (32768) always alerts.
- R8: When the alert fires, the triggering sample replaces the reference. Later movement is measured from it, and smaller moves before it do not move the reference.
- R9: alert_o stays 1 until stat_clr_i is 1 at a clock edge. If a new alert fires at the same edge as a clear, alert_o stays 1.
- R10: irq_o equals alert_o while irq_en_i is 1 and is 0 otherwise. irq_en_i does not affect alert_o.
- R11: Samples presented with angle_vld_i = 0 neither set alert_o nor change the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| angle_i | input | 16 | Angle sample, top bit = 180° |
| angle_vld_i | input | 1 | Angle sample strobe |
| thresh_i | input | 16 | Movement threshold in counts, 0 = off |
| irq_en_i | input | 1 | Interrupt enable |
| stat_clr_i | input | 1 | Clear pulse for the status flag |
| alert_o | output | 1 | Sticky movement alert status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit angle, clamp limits of 9 and 32749, and two reset synchronizer stages. With these values both clamp edges can be probed exactly, one count either side. The half-turn move of 32768, whose magnitude needs the extra result bit, can also be reached. Directed phases step across the seam in both directions, place moves right at the threshold, and walk the angle in sub-threshold increments until the sum crosses. A long random stretch then mixes threshold values, including zero, with enable, clear and strobe patterns.

// File: rtl/angle_alert_pkg.sv
package angle_alert_pkg;
  localparam int ANGLE_W_DEF  = 16;
  localparam int THR_MIN_DEF  = 9;
  localparam int THR_MAX_DEF  = 32749;
  localparam int SYNC_ST_DEF  = 2;
endpackage

// File: rtl/angle_alert_rst_sync.sv
module angle_alert_rst_sync #(
  parameter int STAGES = angle_alert_pkg::SYNC_ST_DEF
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/angle_alert_thr_cond.sv
module angle_alert_thr_cond #(
  parameter int W       = angle_alert_pkg::ANGLE_W_DEF,
  parameter int THR_MIN = angle_alert_pkg::THR_MIN_DEF,
  parameter int THR_MAX = angle_alert_pkg::THR_MAX_DEF
) (
  input  logic [W-1:0] thr_i,
  output logic         active_o,
  output logic [W-1:0] eff_o
);
  localparam logic [W-1:0] MIN_V = W'(THR_MIN);
  localparam logic [W-1:0] MAX_V = W'(THR_MAX);

  always_comb begin
    active_o = |thr_i;
    if (thr_i < MIN_V)      eff_o = MIN_V;
    else if (thr_i > MAX_V) eff_o = MAX_V;
    else                    eff_o = thr_i;
  end
endmodule

// File: rtl/angle_alert_wrap_mag.sv
module angle_alert_wrap_mag #(
  parameter int W = angle_alert_pkg::ANGLE_W_DEF
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] ref_i,
  output logic [W:0]   mag_o
);
  logic [W-1:0] diff;

  always_comb begin
    diff = cur_i - ref_i;
    if (diff[W-1]) mag_o = {1'b0, ~diff} + (W+1)'(1);
    else           mag_o = {1'b0, diff};
  end
endmodule

// File: rtl/angle_delta_alert.sv
module angle_delta_alert #(
  parameter int ANGLE_W     = angle_alert_pkg::ANGLE_W_DEF,
  parameter int THR_MIN     = angle_alert_pkg::THR_MIN_DEF,
  parameter int THR_MAX     = angle_alert_pkg::THR_MAX_DEF,
  parameter int SYNC_STAGES = angle_alert_pkg::SYNC_ST_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               angle_vld_i,
  input  logic [ANGLE_W-1:0] thresh_i,
  input  logic               irq_en_i,
  input  logic               stat_clr_i,
  output logic               alert_o,
  output logic               irq_o
);
  localparam int MAG_W = ANGLE_W + 1;

  logic               rst_sync_n;
  logic               active_w;
  logic [ANGLE_W-1:0] eff_thr_w;
  logic [MAG_W-1:0]   mag_w;

  logic [ANGLE_W-1:0] ref_q, ref_d;
  logic               ref_vld_q, ref_vld_d;
  logic               stat_q, stat_d;
  logic               ref_ld, vld_ld, stat_ld;
  logic               fire_w;

  angle_alert_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  angle_alert_thr_cond #(.W(ANGLE_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)) u_thr (
    .thr_i    (thresh_i),
    .active_o (active_w),
    .eff_o    (eff_thr_w)
  );

  angle_alert_wrap_mag #(.W(ANGLE_W)) u_mag (
    .cur_i (angle_i),
    .ref_i (ref_q),
    .mag_o (mag_w)
  );

  // next-state
  always_comb begin
    ref_d     = ref_q;
    ref_vld_d = ref_vld_q;
    stat_d    = stat_q;
    fire_w    = 1'b0;
    if (!active_w) begin
      ref_vld_d = 1'b0;
    end else if (angle_vld_i) begin
      if (!ref_vld_q) begin
        ref_d     = angle_i;
        ref_vld_d = 1'b1;
      end else if (mag_w > {1'b0, eff_thr_w}) begin
        fire_w = 1'b1;
        ref_d  = angle_i;
      end
    end
    if (stat_clr_i) stat_d = 1'b0;
    if (fire_w)     stat_d = 1'b1;
  end

  // clock enables
  assign ref_ld  = active_w && angle_vld_i && (fire_w || !ref_vld_q);
  assign vld_ld  = ref_vld_d != ref_vld_q;
  assign stat_ld = stat_clr_i || fire_w;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  ref_q <= '0;
    else if (ref_ld)  ref_q <= ref_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  ref_vld_q <= 1'b0;
    else if (vld_ld)  ref_vld_q <= ref_vld_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= 1'b0;
    else if (stat_ld) stat_q <= stat_d;
  end

  assign alert_o = stat_q;
  assign irq_o   = stat_q & irq_en_i;
endmodule

// File: rtl/angle_delta_alert_chk.sv
module angle_delta_alert_chk #(
  parameter int ANGLE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ANGLE_W-1:0] angle_i,
  input logic               angle_vld_i,
  input logic [ANGLE_W-1:0] thresh_i,
  input logic               irq_en_i,
  input logic               stat_clr_i,
  input logic               alert_o,
  input logic               irq_o,
  input logic               fire_w,
  input logic               ref_vld_q,
  input logic [ANGLE_W-1:0] ref_q
);
  a_r9_sticky_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o && !stat_clr_i |=> alert_o);

  a_r9_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && !angle_vld_i |=> !alert_o);

  a_r2_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i == '0) && !alert_o |=> !alert_o);

  a_r2_off_drops_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i == '0) |=> !ref_vld_q);

  a_r11_idle_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !angle_vld_i && !alert_o |=> !alert_o);

  a_r11_idle_keeps_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !angle_vld_i && ref_vld_q && (thresh_i != '0) |=> $stable(ref_q));

  a_r3_first_sample_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_vld_q && !alert_o |=> !alert_o);

  a_r8_ref_takes_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_w |=> ref_q == $past(angle_i));

  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i && alert_o);
endmodule

bind angle_delta_alert angle_delta_alert_chk #(.ANGLE_W(ANGLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .angle_i     (angle_i),
  .angle_vld_i (angle_vld_i),
  .thresh_i    (thresh_i),
  .irq_en_i    (irq_en_i),
  .stat_clr_i  (stat_clr_i),
  .alert_o     (alert_o),
  .irq_o       (irq_o),
  .fire_w      (fire_w),
  .ref_vld_q   (ref_vld_q),
  .ref_q       (ref_q)
);

// File: tb/angle_delta_alert_test.sv
module angle_delta_alert_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] angle = '0;
  logic        vld = 1'b0;
  logic [15:0] thr = '0;
  logic        en = 1'b0;
  logic        clr = 1'b0;
  logic        alert, irq;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string tag     = "R1";

  // behavioural reference state
  int m_ref  = 0;
  bit m_have = 0;
  bit m_stat = 0;

  always #10 clk = ~clk;

  angle_delta_alert uut (
    .clk_i(clk), .rst_ni(rst_n), .angle_i(angle), .angle_vld_i(vld),
    .thresh_i(thr), .irq_en_i(en), .stat_clr_i(clr),
    .alert_o(alert), .irq_o(irq)
  );

  function automatic void model_next();
    int t, d, m;
    bit f;
    f = 0;
    if (!rst_n) begin
      m_have = 0; m_stat = 0;
      return;
    end
    if (thr == 0) begin
      m_have = 0;
    end else begin
      t = (thr < 9) ? 9 : ((thr > 32749) ? 32749 : int'(thr));
      if (vld) begin
        if (!m_have) begin
          m_ref = angle; m_have = 1;
        end else begin
          d = (int'(angle) - m_ref) & 65535;
          if (d >= 32768) d -= 65536;
          m = (d < 0) ? -d : d;
          if (m > t) begin f = 1; m_ref = angle; end
        end
      end
    end
    if (clr) m_stat = 0;
    if (f)   m_stat = 1;
  endfunction

  task automatic compare();
    bit exp_irq;
    exp_irq = m_stat & en;
    vectors++;
    if (alert !== m_stat) begin
      errors++;
      $display("FAIL %s: alert_o=%b expected %b at %0t", tag, alert, m_stat, $time);
    end
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", tag, irq, exp_irq, $time);
    end
  endtask

  task automatic step(input int a, input bit v, input int t, input bit e, input bit c);
    @(negedge clk);
    compare();
    angle = 16'(a); vld = v; thr = 16'(t); en = e; clr = c;
    model_next();
  endtask

  task automatic clear_all();
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(100, 1, 0, 1, 0);

    // R2: threshold zero keeps the block off
    tag = "R2";
    step(0, 1, 0, 1, 0);
    step(30000, 1, 0, 1, 0);
    step(1000, 1, 0, 1, 0);
    step(1000, 1, 0, 1, 0);

    // R3: first sample after enabling is the reference only
    tag = "R3";
    step(5000, 1, 1000, 1, 0);
    step(5500, 1, 1000, 1, 0);
    step(5500, 1, 1000, 1, 0);
    step(5000, 1, 0, 1, 0);
    step(40000, 1, 1000, 1, 0);
    step(40000, 1, 1000, 1, 0);

    // R4: seam crossing both ways
    tag = "R4";
    step(65500, 1, 0, 1, 0);
    step(65500, 1, 100, 1, 0);
    step(200, 1, 100, 1, 0);
    step(200, 1, 100, 1, 0);
    clear_all();
    step(65500, 1, 100, 1, 0);
    step(65400, 1, 100, 1, 0);
    step(150, 1, 100, 1, 0);
    step(150, 1, 100, 1, 0);
    clear_all();

    // R5: equal does not fire, one more does
    tag = "R5";
    step(10000, 1, 500, 1, 0);
    step(10500, 1, 500, 1, 0);
    step(9500, 1, 500, 1, 0);
    step(10501, 1, 500, 1, 0);
    step(10501, 0, 500, 1, 0);
    clear_all();

    // R6: low clamp
    tag = "R6";
    step(2000, 1, 3, 1, 0);
    step(2009, 1, 3, 1, 0);
    step(1991, 1, 3, 1, 0);
    step(2010, 1, 3, 1, 0);
    step(2010, 0, 3, 1, 0);
    clear_all();

    // R7: high clamp and half-turn
    tag = "R7";
    step(0, 1, 40000, 1, 0);
    step(32749, 1, 40000, 1, 0);
    step(65535 - 32748, 1, 40000, 1, 0);
    step(32750, 1, 40000, 1, 0);
    step(32750, 0, 40000, 1, 0);
    clear_all();
    step(100, 1, 65535, 1, 0);
    step(100 + 32768, 1, 65535, 1, 0);
    step(0, 0, 65535, 1, 0);
    clear_all();

    // R8: reference only moves on a fire
    tag = "R8";
    step(1000, 1, 300, 1, 0);
    step(1200, 1, 300, 1, 0);
    step(1250, 1, 300, 1, 0);
    step(1301, 1, 300, 1, 0);
    step(1301, 0, 300, 1, 1);
    step(1500, 1, 300, 1, 0);
    step(1601, 1, 300, 1, 0);
    step(1602, 1, 300, 1, 0);
    step(1602, 0, 300, 1, 0);
    clear_all();

    // R9: sticky status, set beats clear
    tag = "R9";
    step(20000, 1, 50, 1, 0);
    step(21000, 1, 50, 1, 0);
    for (int i = 0; i < 4; i++) step(21000, 0, 50, 1, 0);
    step(22000, 1, 50, 1, 1);
    step(22000, 0, 50, 1, 0);
    step(22000, 0, 50, 1, 1);
    step(22000, 0, 50, 1, 0);

    // R10: interrupt gate does not touch status
    tag = "R10";
    step(23000, 1, 50, 0, 0);
    step(23000, 0, 50, 0, 0);
    step(23000, 0, 50, 1, 0);
    step(23000, 0, 50, 0, 0);
    step(23000, 0, 50, 1, 0);
    clear_all();

    // R11: unstrobed samples ignored
    tag = "R11";
    step(30000, 1, 100, 1, 0);
    step(60000, 0, 100, 1, 0);
    step(5, 0, 100, 1, 0);
    step(30050, 1, 100, 1, 0);
    step(30050, 0, 100, 1, 0);
    step(30201, 1, 100, 1, 0);
    step(30201, 0, 100, 1, 0);
    clear_all();

    // mixed random stretch (R2 R4 R5 R9 R10 R11)
    tag = "R5";
    begin
      int a, t;
      a = 0; t = 200;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 99) < 3) begin
          case ($urandom_range(0, 5))
            0: t = 0;
            1: t = $urandom_range(1, 8);
            2: t = $urandom_range(9, 400);
            3: t = $urandom_range(400, 32749);
            4: t = $urandom_range(32750, 65535);
            default: t = $urandom_range(0, 65535);
          endcase
        end
        if ($urandom_range(0, 9) == 0) a = $urandom_range(0, 65535);
        else a = (a + $urandom_range(0, 600) - 300) & 65535;
        step(a, $urandom_range(0, 3) != 0, t, $urandom_range(0, 1) == 1,
             $urandom_range(0, 15) == 0);
      end
    end
    @(negedge clk);
    compare();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule